// File: doc/BRIEF.md
# Sliced Last-Level Cache Tag Lookup

This block models the tag side of a last-level cache that is split into several slices. A request carries a physical address. An XOR hash over high address bits picks the slice. The bits just above the line offset pick a set inside that slice. The tags of that set's ways are then compared with the request. No data is stored: the block answers whether the line is present and where it lives or has just been placed.

On a miss the line is installed. It goes into the lowest-numbered empty way, or, if the set is full, into the least recently used way. Recency is kept exactly with a per-way age rank. A synchronous clear input empties the whole structure within a fixed number of cycles, and requests are held off while it runs. The slice count (2 or 4), the associativity (12 or 16), the set-index width and the address width are parameters. With `SET_BITS = 11` the set index is address bits 16:6 and each slice holds 2048 sets. The default is smaller so that the default build stays compact.

Top module: `slice_tag_lookup`

## Requirements
- R1: While `rst` is high, `req_ready` and `resp_valid` are low. After reset every way is empty, so the first access to any address misses.
- R2: Address bits 5:0 (the offset within a 64-byte line) play no part in the lookup. Two addresses that differ only there hit the same way.
- R3: The set index is `req_addr[6+SET_BITS-1:6]` and is returned on `resp_set`.
- R4: With 4 slices, `resp_slice[0]` (h1) is the XOR of address bits {18,19,21,23,25,27,29,30,31}. `resp_slice[1]` (h2) is the XOR of bits {17,19,20,21,22,23,24,26,28,29,31}.
- R5: With 2 slices, the single-bit `resp_slice` is the XOR of address bits {17,18,20,22,24,25,26,27,28,30}, which equals h1 XOR h2.
- R6: When `FOLD_B32` is 1, address bit 32 is also XORed into h1 (4 slices) or into the single slice bit (2 slices). When it is 0, bit 32 has no effect on the slice.
- R7: With `WAYS` ways, `WAYS` distinct lines of one slice and set all stay resident. One more distinct line evicts the least recently used one, which then misses when accessed again.
- R8: A hit makes its way the most recent. A miss fills the lowest-numbered empty way, or else the oldest way, and reports that way on `resp_way`.
- R9: Each accepted request (`req_valid && req_ready`) produces exactly one response with `resp_valid` high in the next cycle. A request in the very next cycle sees the state written by the previous one.
- R10: A one-cycle `clr_req` empties every way of every slice. `req_ready` stays low for at most `2**SET_BITS + 1` cycles, counting the cycle in which `clr_req` is high.
- R11: The stored tag is every address bit above the set index. Addresses that share slice and set but differ in any of those bits are distinct lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr_req | input | 1 | One-cycle request to empty all ways |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Physical address of the request |
| resp_valid | output | 1 | Response present (one cycle after acceptance) |
| resp_hit | output | 1 | 1 = line was present, 0 = line was installed |
| resp_slice | output | log2(SLICES) | Slice chosen by the hash |
| resp_set | output | SET_BITS | Set index within the slice |
| resp_way | output | log2(WAYS) | Way that hit or was filled |

## Verification
Every response is due exactly one cycle after its acceptance edge. The bench drives inputs just after a falling edge and decides acceptance from `req_ready` sampled 1 ns later. At the next falling edge it compares every response field against a reference computed for that acceptance. Because `resp_valid` is compared against the expected value every cycle, a missing, extra or late response is caught in the cycle it occurs. The clear is measured by counting the cycles in which `req_ready` is low after the `clr_req` pulse, and requests offered during that window must produce no response in the following cycle. Two instances (4 slices/16 ways with bit 32 folded, and 2 slices/12 ways without it) share the same stimulus, so both hash variants and both eviction depths are covered.

// File: rtl/slice_tag_pkg.sv
package slice_tag_pkg;

  localparam int LINE_BITS = 6;

  // Address masks selecting the bits that each slice-hash output folds together.
  localparam logic [63:0] SEL_H1   = 64'h0000_0000_EAAC_0000;
  localparam logic [63:0] SEL_H2   = 64'h0000_0000_B5FA_0000;
  localparam logic [63:0] SEL_PAIR = 64'h0000_0000_5F56_0000;
  localparam logic [63:0] SEL_B32  = 64'h0000_0001_0000_0000;

  function automatic logic masked_parity(input logic [63:0] a, input logic [63:0] m);
    return ^(a & m);
  endfunction

  // Slice number for a given slice count; bit 32 optionally joins h1 / the pair bit.
  function automatic logic [1:0] slice_of(input logic [63:0] a, input int slices,
                                          input bit fold32);
    logic [63:0] m1;
    logic [63:0] mp;
    m1 = fold32 ? (SEL_H1 | SEL_B32) : SEL_H1;
    mp = fold32 ? (SEL_PAIR | SEL_B32) : SEL_PAIR;
    if (slices == 4) return {masked_parity(a, SEL_H2), masked_parity(a, m1)};
    else             return {1'b0, masked_parity(a, mp)};
  endfunction

endpackage

// File: rtl/slice_hash_unit.sv
module slice_hash_unit #(
  parameter int ADDR_W   = 34,
  parameter int SLICES   = 4,
  parameter bit FOLD_B32 = 1'b1,
  localparam int SLICE_W = $clog2(SLICES)
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [SLICE_W-1:0] slice_o
);
  import slice_tag_pkg::*;

  logic [63:0] wide_addr;
  logic [1:0]  both_bits;

  assign wide_addr = {{(64-ADDR_W){1'b0}}, addr};
  assign both_bits = slice_of(wide_addr, SLICES, FOLD_B32);

  generate
    if (SLICES == 4) begin : g_four
      assign slice_o = both_bits;
    end else begin : g_two
      assign slice_o = both_bits[0];
    end
  endgenerate
endmodule

// File: rtl/way_probe.sv
module way_probe #(
  parameter int WAYS  = 16,
  parameter int TAG_W = 25,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [TAG_W-1:0] row_tag [WAYS],
  input  logic [WAYS-1:0]  row_val,
  input  logic [WAY_W-1:0] row_age [WAYS],
  input  logic [TAG_W-1:0] probe_tag,
  output logic [WAYS-1:0]  match_vec,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [WAY_W-1:0] victim_way
);
  logic             any_empty;
  logic [WAY_W-1:0] first_empty;
  logic [WAY_W-1:0] oldest_way;

  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_cmp
      assign match_vec[gw] = row_val[gw] && (row_tag[gw] == probe_tag);
    end
  endgenerate

  assign hit = |match_vec;

  always_comb begin
    hit_way     = '0;
    any_empty   = 1'b0;
    first_empty = '0;
    oldest_way  = '0;
    // Walk downward so the lowest-numbered candidate is the one that remains.
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_vec[w]) hit_way = WAY_W'(w);
      if (!row_val[w]) begin
        any_empty   = 1'b1;
        first_empty = WAY_W'(w);
      end
      if (row_age[w] == WAY_W'(WAYS - 1)) oldest_way = WAY_W'(w);
    end
    victim_way = any_empty ? first_empty : oldest_way;
  end
endmodule

// File: rtl/age_rank_update.sv
module age_rank_update #(
  parameter int WAYS = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAY_W-1:0] age_in  [WAYS],
  input  logic [WAY_W-1:0] touched,
  output logic [WAY_W-1:0] age_out [WAYS]
);
  logic [WAY_W-1:0] pivot;

  always_comb begin
    pivot = age_in[touched];
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touched)  age_out[w] = '0;
      else if (age_in[w] < pivot) age_out[w] = age_in[w] + 1'b1;
      else                        age_out[w] = age_in[w];
    end
  end
endmodule

// File: rtl/clear_sweeper.sv
module clear_sweeper #(
  parameter int SET_BITS = 3,
  localparam int NSETS = 1 << SET_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  output logic                busy,
  output logic [SET_BITS-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end else if (idx == SET_BITS'(NSETS - 1)) begin
      busy <= 1'b0;
    end else begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/slice_tag_lookup.sv
module slice_tag_lookup #(
  parameter int ADDR_W   = 34,
  parameter int SLICES   = 4,
  parameter int WAYS     = 16,
  parameter int SET_BITS = 3,
  parameter bit FOLD_B32 = 1'b1,
  localparam int SLICE_W = $clog2(SLICES),
  localparam int WAY_W   = $clog2(WAYS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_req,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                resp_valid,
  output logic                resp_hit,
  output logic [SLICE_W-1:0]  resp_slice,
  output logic [SET_BITS-1:0] resp_set,
  output logic [WAY_W-1:0]    resp_way
);
  import slice_tag_pkg::*;

  localparam int NSETS = 1 << SET_BITS;
  localparam int TAG_W = ADDR_W - LINE_BITS - SET_BITS;

  logic [TAG_W-1:0] tag_q [SLICES][NSETS][WAYS];
  logic [WAYS-1:0]  val_q [SLICES][NSETS];
  logic [WAY_W-1:0] age_q [SLICES][NSETS][WAYS];

  // Named internal events for the bound checker.
  logic                acc;
  logic                clr_busy;
  logic [SET_BITS-1:0] clr_idx;
  logic [WAYS-1:0]     match_vec;

  logic [SLICE_W-1:0]  req_slice;
  logic [SET_BITS-1:0] req_set;
  logic [TAG_W-1:0]    req_tag;

  logic [TAG_W-1:0]    row_tag [WAYS];
  logic [WAYS-1:0]     row_val;
  logic [WAY_W-1:0]    row_age [WAYS];
  logic [WAY_W-1:0]    next_age [WAYS];
  logic                probe_hit;
  logic [WAY_W-1:0]    hit_way;
  logic [WAY_W-1:0]    victim_way;
  logic [WAY_W-1:0]    touch_way;

  assign req_ready = !rst && !clr_busy && !clr_req;
  assign acc       = req_valid && req_ready;

  assign req_set = req_addr[LINE_BITS +: SET_BITS];
  assign req_tag = req_addr[ADDR_W-1 : LINE_BITS + SET_BITS];

  slice_hash_unit #(
    .ADDR_W  (ADDR_W),
    .SLICES  (SLICES),
    .FOLD_B32(FOLD_B32)
  ) u_hash (
    .addr   (req_addr),
    .slice_o(req_slice)
  );

  clear_sweeper #(.SET_BITS(SET_BITS)) u_sweep (
    .clk  (clk),
    .rst  (rst),
    .start(clr_req),
    .busy (clr_busy),
    .idx  (clr_idx)
  );

  always_comb begin
    row_val = val_q[req_slice][req_set];
    for (int w = 0; w < WAYS; w++) begin
      row_tag[w] = tag_q[req_slice][req_set][w];
      row_age[w] = age_q[req_slice][req_set][w];
    end
  end

  way_probe #(.WAYS(WAYS), .TAG_W(TAG_W)) u_probe (
    .row_tag   (row_tag),
    .row_val   (row_val),
    .row_age   (row_age),
    .probe_tag (req_tag),
    .match_vec (match_vec),
    .hit       (probe_hit),
    .hit_way   (hit_way),
    .victim_way(victim_way)
  );

  assign touch_way = probe_hit ? hit_way : victim_way;

  age_rank_update #(.WAYS(WAYS)) u_age (
    .age_in (row_age),
    .touched(touch_way),
    .age_out(next_age)
  );

  // State arrays: reset and clear return every rank to its way number.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SLICES; s++) begin
        for (int n = 0; n < NSETS; n++) begin
          val_q[s][n] <= '0;
          for (int w = 0; w < WAYS; w++) age_q[s][n][w] <= WAY_W'(w);
        end
      end
    end else if (clr_busy) begin
      for (int s = 0; s < SLICES; s++) begin
        val_q[s][clr_idx] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][clr_idx][w] <= WAY_W'(w);
      end
    end else if (acc) begin
      tag_q[req_slice][req_set][touch_way] <= req_tag;
      val_q[req_slice][req_set][touch_way] <= 1'b1;
      for (int w = 0; w < WAYS; w++) age_q[req_slice][req_set][w] <= next_age[w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_slice <= '0;
      resp_set   <= '0;
      resp_way   <= '0;
    end else begin
      resp_valid <= acc;
      if (acc) begin
        resp_hit   <= probe_hit;
        resp_slice <= req_slice;
        resp_set   <= req_set;
        resp_way   <= touch_way;
      end
    end
  end
endmodule

// File: rtl/slice_tag_lookup_chk.sv
module slice_tag_lookup_chk #(
  parameter int WAYS  = 16,
  parameter int NSETS = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst,
  input logic             acc,
  input logic             clr_req,
  input logic             clr_busy,
  input logic             req_ready,
  input logic             resp_valid,
  input logic [WAY_W-1:0] resp_way,
  input logic [WAYS-1:0]  match_vec
);
  logic [31:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst) busy_run <= '0;
    else     busy_run <= clr_busy ? busy_run + 1 : '0;
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk) rst |=> !resp_valid);

  a_r9_resp_next_cycle: assert property (@(posedge clk) disable iff (rst)
    resp_valid == $past(acc));

  a_r8_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  a_r7_way_in_range: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (32'(resp_way) < WAYS));

  a_r10_held_off: assert property (@(posedge clk) disable iff (rst)
    (clr_busy || clr_req) |-> !req_ready);

  a_r10_no_resp_after_busy: assert property (@(posedge clk) disable iff (rst)
    clr_busy |=> !resp_valid);

  a_r10_bounded_sweep: assert property (@(posedge clk) disable iff (rst)
    busy_run <= 32'(NSETS));
endmodule

bind slice_tag_lookup slice_tag_lookup_chk #(
  .WAYS (WAYS),
  .NSETS(1 << SET_BITS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc       (acc),
  .clr_req   (clr_req),
  .clr_busy  (clr_busy),
  .req_ready (req_ready),
  .resp_valid(resp_valid),
  .resp_way  (resp_way),
  .match_vec (match_vec)
);

// File: tb/slice_tag_lookup_bench.sv
module slice_tag_lookup_bench;
  localparam int AW   = 34;
  localparam int SB   = 3;
  localparam int SETS = 1 << SB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic rv  = 1'b0;
  logic [AW-1:0] ra = '0;

  always #10 clk = ~clk;

  logic          rdy0, v0, h0;
  logic [1:0]    sl0;
  logic [SB-1:0] st0;
  logic [3:0]    w0;
  logic          rdy1, v1, h1;
  logic [0:0]    sl1;
  logic [SB-1:0] st1;
  logic [3:0]    w1;

  slice_tag_lookup #(.ADDR_W(AW), .SLICES(4), .WAYS(16), .SET_BITS(SB), .FOLD_B32(1'b1))
  u_slice_tag_lookup (
    .clk(clk), .rst(rst), .clr_req(clr), .req_valid(rv), .req_ready(rdy0), .req_addr(ra),
    .resp_valid(v0), .resp_hit(h0), .resp_slice(sl0), .resp_set(st0), .resp_way(w0));

  slice_tag_lookup #(.ADDR_W(AW), .SLICES(2), .WAYS(12), .SET_BITS(SB), .FOLD_B32(1'b0))
  u_slice_tag_lookup_two (
    .clk(clk), .rst(rst), .clr_req(clr), .req_valid(rv), .req_ready(rdy1), .req_addr(ra),
    .resp_valid(v1), .resp_hit(h1), .resp_slice(sl1), .resp_set(st1), .resp_way(w1));

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  string phase = "R1";

  // Behavioural reference: per-line tag, presence and last-use stamp.
  longint unsigned m_tag [2][4][SETS][16];
  bit              m_val [2][4][SETS][16];
  longint          m_use [2][4][SETS][16];
  longint          stamp = 1;

  bit     e_v   [2];
  bit     e_hit [2];
  int     e_sl  [2];
  int     e_st  [2];
  int     e_way [2];
  string  e_tag [2];

  function automatic int n_ways(input int i);  return (i == 0) ? 16 : 12; endfunction
  function automatic int n_slc(input int i);   return (i == 0) ? 4 : 2;   endfunction
  function automatic bit has_b32(input int i); return (i == 0);           endfunction

  function automatic int ref_slice(input int i, input longint unsigned a);
    bit p1 = 0, p2 = 0, pp = 0;
    for (int b = 0; b < AW; b++) begin
      bit x = a[b];
      if (b inside {18, 19, 21, 23, 25, 27, 29, 30, 31}) p1 ^= x;
      if (b inside {17, 19, 20, 21, 22, 23, 24, 26, 28, 29, 31}) p2 ^= x;
      if (b inside {17, 18, 20, 22, 24, 25, 26, 27, 28, 30}) pp ^= x;
      if (b == 32 && has_b32(i)) begin p1 ^= x; pp ^= x; end
    end
    return (n_slc(i) == 4) ? (int'(p2) * 2 + int'(p1)) : int'(pp);
  endfunction

  task automatic model_access(input int i, input longint unsigned a);
    int s = ref_slice(i, a);
    int n = int'((a >> 6) % SETS);
    longint unsigned t = a >> (6 + SB);
    int way = -1;
    bit hit = 0;
    for (int w = 0; w < n_ways(i); w++)
      if (way < 0 && m_val[i][s][n][w] && m_tag[i][s][n][w] == t) begin way = w; hit = 1; end
    for (int w = 0; w < n_ways(i); w++)
      if (way < 0 && !m_val[i][s][n][w]) way = w;
    if (way < 0) begin
      longint best = 64'h7fff_ffff_ffff_ffff;
      for (int w = 0; w < n_ways(i); w++)
        if (m_use[i][s][n][w] < best) begin best = m_use[i][s][n][w]; way = w; end
    end
    m_tag[i][s][n][way] = t;
    m_val[i][s][n][way] = 1;
    m_use[i][s][n][way] = stamp;
    stamp++;
    e_hit[i] = hit; e_sl[i] = s; e_st[i] = n; e_way[i] = way; e_tag[i] = phase;
  endtask

  task automatic model_clear();
    for (int i = 0; i < 2; i++)
      for (int s = 0; s < 4; s++)
        for (int n = 0; n < SETS; n++)
          for (int w = 0; w < 16; w++) m_val[i][s][n][w] = 0;
  endtask

  task automatic check(input string tg, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tg, what, act, exp);
    end
  endtask

  task automatic compare_outputs();
    longint av [2], ah [2], as_ [2], at [2], aw [2];
    av[0] = v0; ah[0] = h0; as_[0] = sl0; at[0] = st0; aw[0] = w0;
    av[1] = v1; ah[1] = h1; as_[1] = sl1; at[1] = st1; aw[1] = w1;
    for (int i = 0; i < 2; i++) begin
      check("R9", $sformatf("inst%0d resp_valid", i), av[i], longint'(e_v[i]));
      if (e_v[i]) begin
        string stag = (e_tag[i] == "R6") ? "R6" : ((i == 0) ? "R4" : "R5");
        check(e_tag[i], $sformatf("inst%0d resp_hit", i), ah[i], longint'(e_hit[i]));
        check(stag, $sformatf("inst%0d resp_slice", i), as_[i], longint'(e_sl[i]));
        check("R3", $sformatf("inst%0d resp_set", i), at[i], longint'(e_st[i]));
        check(e_tag[i], $sformatf("inst%0d resp_way (R8)", i), aw[i], longint'(e_way[i]));
      end
    end
  endtask

  // One clock: check due responses, drive inputs, settle, then update the reference.
  task automatic cyc(input bit v, input longint unsigned a, input bit c, output bit acc);
    @(negedge clk);
    compare_outputs();
    rv = v; ra = AW'(a); clr = c;
    #1;
    acc = v && rdy0 && rdy1 && !rst;
    if (c && !rst) model_clear();
    for (int i = 0; i < 2; i++) begin
      e_v[i] = acc;
      if (acc) model_access(i, a);
    end
  endtask

  task automatic issue(input longint unsigned a);
    bit acc;
    do cyc(1'b1, a, 1'b0, acc); while (!acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int k = 0; k < n; k++) cyc(1'b0, 0, 1'b0, acc);
  endtask

  longint unsigned pick [32];

  task automatic find_lines(input int i, input int want_sl, input int want_st,
                            input int n, input longint unsigned salt);
    int got = 0;
    for (longint unsigned k = 1; got < n && k < 4096; k++) begin
      longint unsigned a = ((k + salt) << (6 + SB)) | (longint'(want_st) << 6);
      if (ref_slice(i, a) == want_sl) begin pick[got] = a; got++; end
    end
  endtask

  initial begin
    bit acc;
    int low_cnt;
    longint unsigned x = 64'h1234_5678_9abc_def1;

    for (int i = 0; i < 2; i++) e_v[i] = 0;
    // R1: reset state
    idle(3);
    check("R1", "req_ready in reset", longint'(rdy0), 0);
    check("R1", "resp_valid in reset", longint'(v0 | v1), 0);
    rst = 1'b0;
    #1;
    check("R1", "req_ready after reset", longint'(rdy0 & rdy1), 1);
    phase = "R1";
    issue(64'h2_3456_7880);

    // R2: offset bits ignored; same line with other offsets hits
    phase = "R2";
    issue(64'h2_3456_78BF);
    issue(64'h2_3456_7895);

    // R9: back-to-back requests to one new line: miss then hit
    phase = "R9";
    issue(64'h1_0AB0_0040);
    issue(64'h1_0AB0_0040);

    // R4/R5/R3: pseudo-random address sweep
    phase = "R4";
    for (int k = 0; k < 48; k++) begin
      x = x * 64'd6364136223846793005 + 64'd1442695040888963407;
      issue(x >> 13);
    end

    // R6: pairs differing only in bit 32
    phase = "R6";
    for (int k = 0; k < 6; k++) begin
      x = x * 64'd6364136223846793005 + 64'd1442695040888963407;
      issue((x >> 17) & ~(64'd1 << 32));
      issue(((x >> 17) & ~(64'd1 << 32)) | (64'd1 << 32));
    end

    // R11: same slice and set, differing only in bit 33 (outside every hash)
    phase = "R11";
    issue(64'h0_00C0_0180);
    issue(64'h2_00C0_0180);
    issue(64'h0_00C0_0180);
    issue(64'h2_00C0_0180);

    // R7: 16-way instance, slice 2 set 5: fill, revisit, overflow, first line misses
    phase = "R7";
    find_lines(0, 2, 5, 17, 100);
    for (int k = 0; k < 16; k++) issue(pick[k]);
    for (int k = 0; k < 16; k++) issue(pick[k]);
    issue(pick[16]);
    issue(pick[0]);
    issue(pick[16]);

    // R7: 12-way instance, slice 1 set 2
    find_lines(1, 1, 2, 13, 900);
    for (int k = 0; k < 12; k++) issue(pick[k]);
    for (int k = 0; k < 12; k++) issue(pick[k]);
    issue(pick[12]);
    issue(pick[0]);

    // R8: touch way 0's line, then overflow must evict the next-oldest
    phase = "R8";
    find_lines(0, 3, 6, 18, 2000);
    for (int k = 0; k < 16; k++) issue(pick[k]);
    issue(pick[0]);
    issue(pick[16]);
    issue(pick[1]);
    issue(pick[0]);

    // R10: clear, hold-off length, ignored requests, everything empty afterwards
    phase = "R10";
    cyc(1'b0, 0, 1'b1, acc);
    low_cnt = rdy0 ? 0 : 1;
    while (!rdy0 && low_cnt < 100) begin
      cyc(1'b1, 64'h2_3456_7880, 1'b0, acc);
      if (!rdy0) low_cnt++;
    end
    check("R10", "ready-low cycles bounded", (low_cnt <= SETS + 1) ? 1 : 0, 1);
    check("R10", "ready returned", longint'(rdy0), 1);
    issue(64'h2_3456_7880);
    issue(pick[0]);
    issue(64'h1_0AB0_0040);

    idle(2);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule